// File: doc/BRIEF.md
# Serial Configuration Length Counter and Startup Sequencer

This block governs the loading phase of a device that takes its configuration as a serial bit stream, one bit per configuration clock. It searches the stream for a start pattern, captures the length value that follows it, and counts every configuration clock from the first one after program release. Completion is declared only when two things are true at once: the frame memory reports that it is full, and the clock count equals the captured length exactly.

On completion a three-step startup runs, one step per clock. DONE rises first, the user outputs are enabled next, and the global set/reset hold is released last. An optional frame check can run on the data frames. When it is enabled and a frame fails, the active-low INIT flag goes low and startup is withheld.

The counter starts before the start pattern arrives. A stray leading bit therefore puts the count one ahead of the data. The match is then missed, and the counter runs on through its terminal value and wraps around before it matches again. Setting the stored length a few counts above the stream length is the usual way to tolerate data that arrives late.

Top module: `cfg_startup_ctrl`

## Requirements
- R1: DONE rises only on a clock where `mem_full` is high and the cycle count (configuration clocks completed since program release) equals the captured length exactly; with an exact-length stream of N bits and length N, DONE is high right after clock N+1.
- R2: The cycle counter is CNT_W bits wide (default 24) and advances on every configuration clock from the first one after program release, counting stray leading bits, start-pattern bits and length bits alike.
- R3: If the count does not equal the length when memory is full, the counter keeps running, wraps to zero and completes when it next equals the length. A stream one bit longer than its length completes 2^CNT_W clocks after the last bit.
- R4: The start pattern is the 8-bit value 0x0F, MSB first, and is found by a sliding search over the incoming bits; the idle stream level is 1. The CNT_W bits that follow it are the length, MSB first. A stream with no valid start pattern never completes: DONE and the output enable stay low and the set/reset hold stays high.
- R5: Startup order: DONE rises on the matching clock (step 0), `out_en` rises one clock later (step 1), and `gsr_hold` falls one clock after that (step 2).
- R6: DONE, `out_en` and the release of `gsr_hold` stay in place once set. After step 2, changes on `din` and `mem_full` have no effect on any output.
- R7: A length set above the stream length by S spare counts completes S+1 clocks after the last bit, provided `mem_full` stays high.
- R8: Frames are FRAME_BITS bits long (default 12: 8 data bits then 4 check bits). They follow the length field and are taken in only while `mem_full` is low. The check register starts at zero and uses polynomial x^4+x+1: each bit is XORed with the register MSB, and the register shifts left with 0x3 applied when that result is 1. A frame is good when the register is zero after its last bit.
- R9: With `crc_en` high, a bad frame drives `init_n` low on that frame's last clock, and `init_n` stays low. Completion is then withheld.
- R10: With `crc_en` low, `init_n` stays high and a bad frame does not prevent completion.
- R11: `prog_n` low on a clock edge returns the block to its idle state: counters cleared, DONE and `out_en` low, `gsr_hold` high, `init_n` high. A fresh exact-length stream then completes as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration clock; one stream bit per rising edge |
| prog_n | input | 1 | Synchronous active-low program/reset |
| din | input | 1 | Serial configuration data |
| mem_full | input | 1 | Frame memory full indication |
| crc_en | input | 1 | Enables the frame check |
| done | output | 1 | Configuration complete, startup step 0 |
| out_en | output | 1 | User outputs enabled, startup step 1 |
| gsr_hold | output | 1 | Global set/reset held while high, released at step 2 |
| init_n | output | 1 | Active-low frame error flag |

## Verification
The bench builds the block with CNT_W set to 8, so the wrap-around after a one-bit misalignment completes 256 clocks after the stream instead of about sixteen million. That window is short enough to measure exactly, along with the spare-count case and the step-by-step startup timing. The other parameters keep their defaults: 12-bit frames and the 0x0F start pattern. The frame-check cases therefore use two real frames, whose check bits the bench computes from the polynomial.

// File: rtl/cfg_startup_ctrl.sv
module cfg_startup_ctrl #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'h0F,
  parameter int FRAME_BITS = 12,
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 4'h3
) (
  input  logic cclk,
  input  logic prog_n,
  input  logic din,
  input  logic mem_full,
  input  logic crc_en,
  output logic done,
  output logic out_en,
  output logic gsr_hold,
  output logic init_n
);

  localparam int FC_W = $clog2(FRAME_BITS + 1);
  localparam int LC_W = $clog2(CNT_W + 1);

  typedef enum logic [2:0] {PH_HUNT, PH_LEN, PH_LOAD, PH_SU0, PH_SU1, PH_SU2} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [CNT_W-1:0]  len_cnt;
  logic [PRE_W-1:0]  win;
  logic [LC_W-1:0]   lbits;
  logic [FC_W-1:0]   fbits;
  logic [CRC_W-1:0]  crc;
  logic              crc_err;

  wire [PRE_W-1:0] win_nx     = {win[PRE_W-2:0], din};
  wire             crc_fb     = crc[CRC_W-1] ^ din;
  wire [CRC_W-1:0] crc_nx     = {crc[CRC_W-2:0], 1'b0} ^ (crc_fb ? CRC_POLY : '0);
  wire             frame_last = (fbits == FC_W'(FRAME_BITS - 1));
  wire             hit        = (phase == PH_LOAD) && mem_full && !crc_err && (cyc_cnt == len_cnt);

  assign init_n = !crc_err;

  always_ff @(posedge cclk) begin
    if (!prog_n) begin
      phase    <= PH_HUNT;
      cyc_cnt  <= '0;
      len_cnt  <= '0;
      win      <= '1;
      lbits    <= '0;
      fbits    <= '0;
      crc      <= '0;
      crc_err  <= 1'b0;
      done     <= 1'b0;
      out_en   <= 1'b0;
      gsr_hold <= 1'b1;
    end else if (phase != PH_SU2) begin
      cyc_cnt <= cyc_cnt + 1'b1;
      case (phase)
        PH_HUNT: begin
          win <= win_nx;
          if (win_nx == PREAMBLE) begin
            phase <= PH_LEN;
            lbits <= '0;
          end
        end
        PH_LEN: begin
          len_cnt <= {len_cnt[CNT_W-2:0], din};
          lbits   <= lbits + 1'b1;
          if (lbits == LC_W'(CNT_W - 1)) phase <= PH_LOAD;
        end
        PH_LOAD: begin
          if (hit) begin
            phase <= PH_SU0;
            done  <= 1'b1;
          end else if (!mem_full) begin
            if (frame_last) begin
              fbits <= '0;
              crc   <= '0;
              if (crc_en && (crc_nx != '0)) crc_err <= 1'b1;
            end else begin
              fbits <= fbits + 1'b1;
              crc   <= crc_nx;
            end
          end
        end
        PH_SU0: begin
          out_en <= 1'b1;
          phase  <= PH_SU1;
        end
        PH_SU1: begin
          gsr_hold <= 1'b0;
          phase    <= PH_SU2;
        end
        default: ;
      endcase
    end
  end

endmodule

module cfg_startup_ctrl_chk #(
  parameter int CNT_W = 24
) (
  input logic             cclk,
  input logic             prog_n,
  input logic             mem_full,
  input logic             crc_en,
  input logic             done,
  input logic             out_en,
  input logic             gsr_hold,
  input logic             init_n,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] len_cnt
);

  p_done_cond_r1: assert property (@(posedge cclk) disable iff (!prog_n)
    $rose(done) |-> ($past(mem_full) && $past(cyc_cnt == len_cnt)));

  p_count_step_r2: assert property (@(posedge cclk) disable iff (!prog_n)
    gsr_hold |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

  p_oe_after_done_r5: assert property (@(posedge cclk) disable iff (!prog_n)
    $rose(out_en) |-> ($past(done) && gsr_hold));

  p_gsr_after_oe_r5: assert property (@(posedge cclk) disable iff (!prog_n)
    $fell(gsr_hold) |-> ($past(out_en) && done));

  p_done_sticky_r6: assert property (@(posedge cclk) disable iff (!prog_n)
    done |=> done);

  p_final_hold_r6: assert property (@(posedge cclk) disable iff (!prog_n)
    !gsr_hold |=> (!gsr_hold && done && out_en));

  p_init_sticky_r9: assert property (@(posedge cclk) disable iff (!prog_n)
    !init_n |=> !init_n);

  p_no_err_when_off_r10: assert property (@(posedge cclk) disable iff (!prog_n)
    (!crc_en && init_n) |=> init_n);

endmodule

bind cfg_startup_ctrl cfg_startup_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cfg_startup_ctrl_tb.sv
module cfg_startup_ctrl_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic prog_n = 1'b0;
  logic din = 1'b1;
  logic mem_full = 1'b0;
  logic crc_en = 1'b0;
  logic done, out_en, gsr_hold, init_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_startup_ctrl #(.CNT_W(W)) u_dut (
    .cclk(clk), .prog_n(prog_n), .din(din), .mem_full(mem_full), .crc_en(crc_en),
    .done(done), .out_en(out_en), .gsr_hold(gsr_hold), .init_n(init_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc4(input logic [7:0] d);
    logic [3:0] c = 4'h0;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[3] ^ d[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b);
    din = b;
    @(negedge clk);
  endtask

  task automatic do_prog();
    prog_n = 1'b0;
    mem_full = 1'b0;
    din = 1'b1;
    @(negedge clk);
    @(negedge clk);
    prog_n = 1'b1;
  endtask

  // stream: stray ones, start pattern, length, two 12-bit frames; returns bit count
  task automatic send_stream(input int stray, input logic [W-1:0] len, input bit bad, output int nbits);
    logic [7:0] d0 = 8'hA5;
    logic [7:0] d1 = 8'h3C;
    logic [3:0] c0 = crc4(d0);
    logic [3:0] c1 = crc4(d1);
    if (bad) c1[0] = ~c1[0];
    nbits = 0;
    for (int i = 0; i < stray; i++) begin send_bit(1'b1); nbits++; end
    for (int i = 7; i >= 0; i--) begin send_bit(8'h0F >> i); nbits++; end
    for (int i = W - 1; i >= 0; i--) begin send_bit(len[i]); nbits++; end
    for (int i = 7; i >= 0; i--) begin send_bit(d0[i]); nbits++; end
    for (int i = 3; i >= 0; i--) begin send_bit(c0[i]); nbits++; end
    for (int i = 7; i >= 0; i--) begin send_bit(d1[i]); nbits++; end
    for (int i = 3; i >= 0; i--) begin send_bit(c1[i]); nbits++; end
    din = 1'b1;
    mem_full = 1'b1;
  endtask

  task automatic wait_done(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
  endtask

  task automatic check_startup(input string req);
    chk({req, " step0 done"}, done, 1);
    chk({req, " step0 out_en"}, out_en, 0);
    chk({req, " step0 gsr_hold"}, gsr_hold, 1);
    @(negedge clk);
    chk({req, " step1 out_en"}, out_en, 1);
    chk({req, " step1 gsr_hold"}, gsr_hold, 1);
    @(negedge clk);
    chk({req, " step2 gsr_hold"}, gsr_hold, 0);
    chk({req, " step2 done"}, done, 1);
  endtask

  task automatic t_reset();
    do_prog();
    chk("R11 reset done", done, 0);
    chk("R11 reset out_en", out_en, 0);
    chk("R11 reset gsr_hold", gsr_hold, 1);
    chk("R11 reset init_n", init_n, 1);
  endtask

  task automatic t_exact();
    int n, k;
    do_prog();
    crc_en = 1'b1;
    send_stream(0, W'(40), 1'b0, n);
    wait_done(300, k);
    chk("R1 exact-length latency", k, 1);
    chk("R8 good frames keep init_n high", init_n, 1);
    check_startup("R5");
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 20; i++) begin
      din = i[0];
      mem_full = i[1];
      @(negedge clk);
      chk("R6 done held", done, 1);
      chk("R6 out_en held", out_en, 1);
      chk("R6 gsr_hold released", gsr_hold, 0);
    end
  endtask

  task automatic t_stray();
    int n, k;
    do_prog();
    crc_en = 1'b0;
    send_stream(1, W'(40), 1'b0, n);
    wait_done(400, k);
    chk("R2 stray bit counted, R3 wrap latency", k, ((40 - n) & ((1 << W) - 1)) + 1);
    chk("R3 wrap latency value", k, 256);
    check_startup("R3");
  endtask

  task automatic t_spare();
    int n, k;
    do_prog();
    send_stream(0, W'(43), 1'b0, n);
    wait_done(400, k);
    chk("R7 spare counts latency", k, 4);
  endtask

  task automatic t_bad_pre();
    int k;
    do_prog();
    for (int i = 7; i >= 0; i--) send_bit(8'h0E >> i);
    for (int i = 0; i < 32; i++) send_bit(1'b1);
    mem_full = 1'b1;
    wait_done(300, k);
    chk("R4 bad start pattern no done", done, 0);
    chk("R4 bad start pattern out_en", out_en, 0);
    chk("R4 bad start pattern gsr_hold", gsr_hold, 1);
  endtask

  task automatic t_crc_bad_en();
    int n, k;
    do_prog();
    crc_en = 1'b1;
    send_stream(0, W'(40), 1'b1, n);
    chk("R9 init_n low after bad frame", init_n, 0);
    wait_done(300, k);
    chk("R9 completion withheld", done, 0);
    chk("R9 init_n stays low", init_n, 0);
    do_prog();
    chk("R11 prog clears init_n", init_n, 1);
  endtask

  task automatic t_crc_bad_dis();
    int n, k;
    do_prog();
    crc_en = 1'b0;
    send_stream(0, W'(40), 1'b1, n);
    wait_done(300, k);
    chk("R10 init_n high with check off", init_n, 1);
    chk("R10 completes with check off", k, 1);
  endtask

  task automatic t_reprog();
    int n, k;
    do_prog();
    chk("R11 prog after final clears done", done, 0);
    chk("R11 prog after final gsr_hold", gsr_hold, 1);
    send_stream(0, W'(40), 1'b0, n);
    wait_done(300, k);
    chk("R11 fresh stream exact latency", k, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_exact();
    t_ignore();
    t_reprog();
    t_stray();
    t_spare();
    t_bad_pre();
    t_crc_bad_en();
    t_crc_bad_dis();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule